// File: doc/BRIEF.md
# Filtered Input Capture Channel

This block is a single capture channel for a general-purpose timer. It takes an asynchronous input pin and the value of a free-running counter that sits outside the block. The pin is synchronised and then passed through a digital glitch filter. A new level is accepted only after a programmable number of consecutive clock samples agree on it. An edge selector picks rising or falling transitions of the filtered level. An event divider then lets one capture through for every 1, 2, 4 or 8 qualified edges. On each capture the counter value is stored in a capture register and a capture flag is raised.

Software drives the channel through a small register port with four words: configuration, flags, event generation and the captured value. Two flags are kept. The capture flag clears on a write of 1 or on a read of the captured value. The overrun flag reports a capture that landed while the capture flag was still pending, and it clears only on a write of 1. A single interrupt request leaves the block. Software can also force a capture through the event word.

Top module: `cap_channel`

## Requirements
- R1: Configuration word (address 0) bits: [1:0] source select, [5:2] filter code, [6] edge select, [8:7] divider code, [9] enable, [10] interrupt enable. Source select 00 makes the channel an output, and a write to the capture word (address 3) then loads it. Any nonzero source select makes the capture word read-only. Only source select 01 takes captures from the pin.
- R2: With filter code k, a level change on the synchronised pin is accepted after 2^k consecutive samples of the new level. A shorter pulse is discarded. With code 0 and no divider, a pin change driven before clock edge 0 is captured at clock edge 3. With code 3 it is captured at edge 10.
- R3: Edge select 0 captures on rising edges of the filtered level. Edge select 1 captures on falling edges.
- R4: Divider code d lets through one capture per 2^d qualified edges, namely the 2^d-th edge.
- R5: Edges cause no capture while enable is 0. On a capture the counter value is loaded into the capture word and flags bit 0 (capture flag, address 1) is set.
- R6: A capture that occurs while the capture flag is set also sets flags bit 1 (overrun). The capture word holds the newest value.
- R7: Writing 1 to flags bit 0 clears the capture flag. A read of address 3 also clears it. The overrun flag clears only by writing 1 to flags bit 1, and reads leave it unchanged.
- R8: Writing 1 to bit 0 of the event word (address 2) forces a capture at that clock edge: the counter is loaded when source select is nonzero, and the capture flag is set.
- R9: The interrupt request is high exactly when the capture flag and interrupt enable are both 1.
- R10: The divider's edge count restarts from zero whenever enable is 0 or the configuration word is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, also the sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_in | input | 1 | Asynchronous capture input |
| cnt_val | input | CNT_W | Free-running counter value |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register word address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for bus_addr (combinational) |
| irq | output | 1 | Capture interrupt request |

## Verification
The bench goes after the exact capture cycle. A pipeline that is one register too long or too short stores a counter value off by one, and the scoreboard catches that. A pulse shorter than the filter window must leave no trace. A filter that does not restart its count would accept it as a capture. The divider is driven through disable and reconfiguration. A divider that keeps its old count fires one edge early. The overrun flag is checked against reads and single-bit clears. A flag that clears on a read, or a capture flag that survives a read of the capture word, shows up as a wrong flags word.

// File: rtl/cap_pkg.sv
// Shared definitions for the capture channel: configuration layout and
// register word addresses. Assumes a 2-bit word address on the bus.
package cap_pkg;

    // Configuration word, LSB first: sel[1:0], flt[5:2], pol[6], div[8:7],
    // en[9], irq_en[10].
    typedef struct packed {
        logic       irq_en;
        logic       en;
        logic [1:0] div;
        logic       pol;
        logic [3:0] flt;
        logic [1:0] sel;
    } cap_cfg_t;

    localparam int CFG_W = $bits(cap_cfg_t);

    localparam logic [1:0] ADDR_CFG   = 2'd0;
    localparam logic [1:0] ADDR_FLAGS = 2'd1;
    localparam logic [1:0] ADDR_EVENT = 2'd2;
    localparam logic [1:0] ADDR_CAPT  = 2'd3;

    localparam logic [1:0] SEL_OUTPUT = 2'b00;
    localparam logic [1:0] SEL_OWNPIN = 2'b01;

endpackage

// File: rtl/cap_sync_filter.sv
// Synchroniser plus consecutive-sample glitch filter.
// The raw pin passes through SYNC_STAGES flops. The filtered level flips
// only after 2^code consecutive synchronised samples that differ from it.
// Assumes the code stays stable while a transition is being qualified.
module cap_sync_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FLT_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [FLT_W-1:0] code,
    output logic             level
);
    localparam int FCNT_W = 2 ** FLT_W;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FCNT_W-1:0]      run_q;
    logic [FCNT_W:0]        run_next;
    logic [FCNT_W:0]        limit;
    logic                   samp;

    assign samp     = sync_q[SYNC_STAGES-1];
    assign run_next = {1'b0, run_q} + 1'b1;
    assign limit    = (FCNT_W+1)'(1) << code;

    // Purpose: shift the raw pin through the synchroniser chain.
    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= pin_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_in};
            end
        end
    endgenerate

    // Purpose: count agreeing samples; accept the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            level <= 1'b0;
        end else if (samp == level) begin
            run_q <= '0;
        end else if (run_next >= limit) begin
            run_q <= '0;
            level <= samp;
        end else begin
            run_q <= run_next[FCNT_W-1:0];
        end
    end

    // A change of the filtered level always moves towards the sample seen.
    p_filter_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (level != $past(level)) |-> (level == $past(samp)));

endmodule

// File: rtl/cap_edge_div.sv
// Edge selector and event divider. Detects the chosen edge of the
// filtered level and passes every 2^div-th one while the channel is active.
// The edge count clears when inactive or on a configuration write.
module cap_edge_div #(
    parameter int DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             level,
    input  logic             pol,
    input  logic [DIV_W-1:0] div,
    input  logic             active,
    input  logic             cfg_wr,
    output logic             fire
);
    localparam int CNT_W = 2 ** DIV_W;

    logic             level_d;
    logic             edge_hit;
    logic [CNT_W-1:0] ecnt_q;
    logic [CNT_W-1:0] last;

    assign edge_hit = active && (pol ? (!level && level_d) : (level && !level_d));
    assign last     = (CNT_W'(1) << div) - 1'b1;
    assign fire     = edge_hit && (ecnt_q == last);

    // Purpose: remember the previous filtered level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    // Purpose: count qualified edges and wrap after the selected ratio.
    always_ff @(posedge clk) begin
        if (!rst_n || !active || cfg_wr) ecnt_q <= '0;
        else if (fire)                   ecnt_q <= '0;
        else if (edge_hit)               ecnt_q <= ecnt_q + 1'b1;
    end

    p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ecnt_q <= last || $past(cfg_wr));

    p_div_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!active || cfg_wr) |=> (ecnt_q == '0));

endmodule

// File: rtl/cap_regs.sv
// Register port, capture word and flags. Writes and read side effects
// take effect at the clock edge; read data is combinational on the address.
// Assumes CNT_W is at least the configuration width.
module cap_regs #(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    input  logic              hw_cap,
    input  logic [CNT_W-1:0]  cnt_val,
    output cap_pkg::cap_cfg_t cfg,
    output logic              cfg_wr,
    output logic              irq
);
    import cap_pkg::*;

    logic [CNT_W-1:0] capt_q;
    logic             flag_q;
    logic             miss_q;
    logic             sw_cap;
    logic             any_cap;
    logic             capt_rd;
    logic             flag_w1c;
    logic             miss_w1c;
    logic             capt_wr;

    assign cfg_wr   = bus_wr && (bus_addr == ADDR_CFG);
    assign sw_cap   = bus_wr && (bus_addr == ADDR_EVENT) && bus_wdata[0];
    assign flag_w1c = bus_wr && (bus_addr == ADDR_FLAGS) && bus_wdata[0];
    assign miss_w1c = bus_wr && (bus_addr == ADDR_FLAGS) && bus_wdata[1];
    assign capt_rd  = bus_rd && (bus_addr == ADDR_CAPT);
    assign capt_wr  = bus_wr && (bus_addr == ADDR_CAPT) && (cfg.sel == SEL_OUTPUT);
    assign any_cap  = hw_cap || sw_cap;
    assign irq      = flag_q && cfg.irq_en;

    // Purpose: hold the configuration word.
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg <= '0;
        else if (cfg_wr) cfg <= cap_cfg_t'(bus_wdata[CFG_W-1:0]);
    end

    // Purpose: load the capture word from the counter or, as output, from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)                                  capt_q <= '0;
        else if (any_cap && cfg.sel != SEL_OUTPUT)   capt_q <= cnt_val;
        else if (capt_wr)                            capt_q <= bus_wdata;
    end

    // Purpose: capture flag, set by a capture, cleared by w1c or data read.
    always_ff @(posedge clk) begin
        if (!rst_n)                     flag_q <= 1'b0;
        else if (any_cap)               flag_q <= 1'b1;
        else if (flag_w1c || capt_rd)   flag_q <= 1'b0;
    end

    // Purpose: overrun flag, set by a capture over a pending one, cleared by w1c.
    always_ff @(posedge clk) begin
        if (!rst_n)                 miss_q <= 1'b0;
        else if (any_cap && flag_q) miss_q <= 1'b1;
        else if (miss_w1c)          miss_q <= 1'b0;
    end

    // Purpose: select the read data for the current address.
    always_comb begin
        unique case (bus_addr)
            ADDR_CFG:   bus_rdata = CNT_W'(cfg);
            ADDR_FLAGS: bus_rdata = CNT_W'({miss_q, flag_q});
            ADDR_EVENT: bus_rdata = '0;
            default:    bus_rdata = capt_q;
        endcase
    end

    p_cap_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        any_cap |=> flag_q);

    p_overrun_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cap && flag_q) |=> miss_q);

    p_miss_clear_only_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(miss_q) |-> $past(miss_w1c));

    p_read_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_CAPT && cfg.sel != SEL_OUTPUT && !any_cap)
        |=> $stable(capt_q));

endmodule

// File: rtl/cap_channel.sv
// Top of the filtered input capture channel: synchroniser and filter,
// edge selector and divider, register port with capture word and flags.
// The counter is supplied from outside.
module cap_channel #(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_in,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    import cap_pkg::*;

    cap_cfg_t cfg;
    logic     cfg_wr;
    logic     level;
    logic     active;
    logic     hw_cap;

    assign active = cfg.en && (cfg.sel == SEL_OWNPIN);

    cap_sync_filter #(
        .SYNC_STAGES (SYNC_STAGES),
        .FLT_W       (4)
    ) i_filter (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in (pin_in),
        .code   (cfg.flt),
        .level  (level)
    );

    cap_edge_div #(
        .DIV_W (2)
    ) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .level  (level),
        .pol    (cfg.pol),
        .div    (cfg.div),
        .active (active),
        .cfg_wr (cfg_wr),
        .fire   (hw_cap)
    );

    cap_regs #(
        .CNT_W (CNT_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .hw_cap    (hw_cap),
        .cnt_val   (cnt_val),
        .cfg       (cfg),
        .cfg_wr    (cfg_wr),
        .irq       (irq)
    );

    p_irq_needs_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> cfg.irq_en);

endmodule

// File: tb/test_cap_channel.sv
module test_cap_channel;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pin_in = 1'b0;
    logic [CNT_W-1:0] cnt_val = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [1:0]       bus_addr = 2'd0;
    logic [CNT_W-1:0] bus_wdata = '0;
    logic [CNT_W-1:0] bus_rdata;
    logic             irq;

    int  n_vec = 0;
    int  n_bad = 0;
    bit  mon_on = 1'b1;
    bit  done = 1'b0;
    logic [CNT_W-1:0] expq[$];

    cap_channel #(.CNT_W(CNT_W)) i_cap_channel (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cnt_val(cnt_val),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    always @(negedge clk) cnt_val <= cnt_val + 1'b1;

    task automatic check(input string tag, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [CNT_W-1:0] mk_cfg(input logic [1:0] sel,
        input logic [3:0] flt, input logic pol, input logic [1:0] dv,
        input logic en, input logic ie);
        return CNT_W'({ie, en, dv, pol, flt, sel});
    endfunction

    task automatic wr(input logic [1:0] a, input logic [CNT_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Driver: set pin at a negedge, optionally push the expected capture value.
    task automatic drive_pin(input logic v, input int lat, input bit push);
        @(negedge clk);
        if (push) expq.push_back(cnt_val + CNT_W'(lat));
        pin_in = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
        for (int i = 0; i < 200 && expq.size() != 0; i++) @(negedge clk);
        repeat (3) @(negedge clk);
        check("queue drained", CNT_W'(expq.size()), '0);
    endtask

    // Monitor: on a raised request, read the capture word and compare.
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on && irq && rst_n) begin
                bus_addr = 2'd3; bus_rd = 1'b1;
                #1;
                if (expq.size() == 0) check("unexpected capture", bus_rdata, 'x);
                else check("capture value", bus_rdata, expq.pop_front());
                @(negedge clk);
                bus_rd = 1'b0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_vec++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [CNT_W-1:0] d;
        logic [CNT_W-1:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // Reset state (R1, R9)
        rd(2'd0, d); check("R1 cfg reset", d, '0);
        rd(2'd1, d); check("R5 flags reset", d, '0);
        check("R9 irq reset", CNT_W'(irq), '0);
        // R1: output mode accepts writes; input mode is read-only
        wr(2'd3, 16'h1234);
        rd(2'd3, d); check("R1 write in output mode", d, 16'h1234);
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd0, 1'b0, 1'b0));
        wr(2'd3, 16'h5555);
        rd(2'd3, d); check("R1 read-only in input mode", d, 16'h1234);
        // R2/R3/R5: filter code 0, rising edges
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd0, 1'b1, 1'b1));
        drive_pin(1'b1, 4, 1'b1); settle(10);
        drive_pin(1'b0, 0, 1'b0); settle(10);   // falling ignored (R3)
        // R2: glitch shorter than 8 samples is discarded
        wr(2'd0, mk_cfg(2'b01, 4'd3, 1'b0, 2'd0, 1'b1, 1'b1));
        drive_pin(1'b1, 0, 1'b0); repeat (4) @(negedge clk);
        pin_in = 1'b0; settle(20);
        rd(2'd1, d); check("R2 glitch rejected", d, '0);
        drive_pin(1'b1, 11, 1'b1); settle(20);
        drive_pin(1'b0, 0, 1'b0); settle(20);
        // R3: falling edge select
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b1, 2'd0, 1'b1, 1'b1));
        drive_pin(1'b1, 0, 1'b0); settle(10);
        drive_pin(1'b0, 4, 1'b1); settle(10);
        // R4: divide by 4, capture on 4th rising edge
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd2, 1'b1, 1'b1));
        for (int k = 0; k < 4; k++) begin
            drive_pin(1'b1, 4, k == 3); repeat (6) @(negedge clk);
            drive_pin(1'b0, 0, 1'b0); repeat (6) @(negedge clk);
        end
        settle(5);
        // R10: divide by 2, count restarts after disable
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1));
        drive_pin(1'b1, 0, 1'b0); repeat (6) @(negedge clk);
        drive_pin(1'b0, 0, 1'b0); repeat (6) @(negedge clk);
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd1, 1'b0, 1'b1));
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd1, 1'b1, 1'b1));
        drive_pin(1'b1, 0, 1'b0); repeat (6) @(negedge clk);
        rd(2'd1, d); check("R10 count restarted", d, '0);
        drive_pin(1'b0, 0, 1'b0); repeat (6) @(negedge clk);
        drive_pin(1'b1, 4, 1'b1); settle(6);
        drive_pin(1'b0, 0, 1'b0); settle(6);
        // R5: disabled channel ignores edges
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1));
        drive_pin(1'b1, 0, 1'b0); repeat (8) @(negedge clk);
        drive_pin(1'b0, 0, 1'b0); repeat (8) @(negedge clk);
        rd(2'd1, d); check("R5 disabled no capture", d, '0);
        // R6/R7/R9: overrun with monitor off, interrupt disabled
        mon_on = 1'b0;
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd0, 1'b1, 1'b0));
        drive_pin(1'b1, 0, 1'b0); repeat (8) @(negedge clk);
        drive_pin(1'b0, 0, 1'b0); repeat (8) @(negedge clk);
        @(negedge clk); v = cnt_val + 16'd4; pin_in = 1'b1;
        repeat (8) @(negedge clk);
        rd(2'd1, d); check("R6 overrun flags", d, 16'd3);
        check("R9 irq gated by enable", CNT_W'(irq), '0);
        rd(2'd3, d); check("R6 newest value kept", d, v);
        rd(2'd1, d); check("R7 read clears only capture flag", d, 16'd2);
        wr(2'd1, 16'd2);
        rd(2'd1, d); check("R7 overrun w1c", d, '0);
        drive_pin(1'b0, 0, 1'b0); repeat (4) @(negedge clk);
        drive_pin(1'b1, 0, 1'b0); repeat (8) @(negedge clk);
        wr(2'd1, 16'd1);
        rd(2'd1, d); check("R7 capture flag w1c", d, '0);
        drive_pin(1'b0, 0, 1'b0); repeat (4) @(negedge clk);
        drive_pin(1'b1, 0, 1'b0); repeat (8) @(negedge clk);
        wr(2'd0, mk_cfg(2'b01, 4'd0, 1'b0, 2'd0, 1'b0, 1'b1));
        #1 check("R9 irq with flag and enable", CNT_W'(irq), 16'd1);
        wr(2'd1, 16'd1);
        drive_pin(1'b0, 0, 1'b0);
        mon_on = 1'b1;
        // R8: software event forces a capture at the write edge
        @(negedge clk);
        expq.push_back(cnt_val + 16'd1);
        bus_addr = 2'd2; bus_wdata = 16'd1; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
        settle(5);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule